// File: doc/BRIEF.md
# Next-PC Instruction Fetch Unit

This block holds the program counter of a single-issue core and works out, every cycle, the address of the instruction to fetch next. The current PC drives the instruction memory address directly. The current instruction word supplies a 16-bit branch offset in its low half and a 26-bit jump field in its low 26 bits. Two select lines from the decoder and an equality flag from the datapath choose the next address.

There are three ways forward. Sequential flow steps one 32-bit word. A taken conditional branch adds a sign-extended, word-scaled offset to the sequential address. An absolute jump keeps the top bits of the sequential address and takes the rest from the instruction. All next-address logic is combinational, and the PC register loads the chosen value on each rising clock edge. An active-low asynchronous reset returns the PC to zero.

Top module: `fetch_pc_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0x00000000, and the first instruction after reset is fetched from address 0.
- R2: When `jump_sel_i` is 0 and a branch is not taken, the PC becomes the old PC plus 4 at the next rising edge.
- R3: `pc_plus4_o` always equals `pc_o` + 4, modulo 2^32.
- R4: A branch is taken only when `branch_sel_i` and `equal_i` are both 1. With either one at 0 and no jump, the flow is sequential.
- R5: On a taken branch, the next PC is `pc_o` + 4 plus the value of `instr_i[15:0]`, sign-extended and shifted left by 2.
- R6: A negative offset (`instr_i[15]` = 1) moves the PC backward. The sum wraps modulo 2^32, so a backward branch near address 0 lands near 0xFFFFFFFC.
- R7: When `jump_sel_i` is 1, the next PC is {(`pc_o`+4)[31:28], `instr_i[25:0]`, 2'b00}.
- R8: When `jump_sel_i` and a taken branch are both present, the jump wins.
- R9: `pc_o[1:0]` is always 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the PC loads on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Current instruction word (offset in [15:0], jump field in [25:0]) |
| branch_sel_i | input | 1 | Current instruction is a conditional branch |
| jump_sel_i | input | 1 | Current instruction is an absolute jump |
| equal_i | input | 1 | Register-equality flag from the datapath |
| pc_o | output | 32 | Current PC, used as the instruction memory address |
| pc_plus4_o | output | 32 | Sequential address, PC + 4 |

## Verification
The assertions assume that the select lines and `instr_i` are settled and known at each rising edge. They also assume that the selects are not undefined while reset is released. They check the PC one cycle after an edge against the inputs sampled at that edge, so they are armed only after the first edge following reset. The bench changes every input only on the falling edge. It draws the select lines and instruction words from a seeded generator and adds directed offsets at the sign boundary and at wrap-around.

// File: rtl/fetch_pc_pkg.sv
package fetch_pc_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2
  } next_src_e;
endpackage

// File: rtl/fetch_pc_seq.sv
module fetch_pc_seq #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] pc_plus4_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
  assign pc_plus4_o = pc_i + STEP_V;
endmodule

// File: rtl/fetch_pc_targets.sv
module fetch_pc_targets #(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int IMM_W   = 16,
  parameter int TGT_W   = 26
) (
  input  logic [ADDR_W-1:0]  pc_plus4_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [ADDR_W-1:0]  br_tgt_o,
  output logic [ADDR_W-1:0]  jmp_tgt_o
);
  localparam int SX_W = ADDR_W - IMM_W - 2;
  localparam int HI_W = ADDR_W - TGT_W - 2;

  logic [IMM_W-1:0]  imm;
  logic [TGT_W-1:0]  tgt;
  logic [ADDR_W-1:0] br_off;
  logic              unused_op;

  assign imm       = instr_i[IMM_W-1:0];
  assign tgt       = instr_i[TGT_W-1:0];
  assign unused_op = ^instr_i[INSTR_W-1:TGT_W];

  // word-scaled, sign-extended offset
  assign br_off   = {{SX_W{imm[IMM_W-1]}}, imm, 2'b00};
  assign br_tgt_o = pc_plus4_i + br_off;

  generate
    if (HI_W > 0) begin : g_region
      assign jmp_tgt_o = {pc_plus4_i[ADDR_W-1 -: HI_W], tgt, 2'b00};
    end else begin : g_flat
      logic unused_pc;
      assign unused_pc = ^pc_plus4_i;
      assign jmp_tgt_o = ADDR_W'({tgt, 2'b00});
    end
  endgenerate
endmodule

// File: rtl/fetch_pc_select.sv
module fetch_pc_select
  import fetch_pc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              branch_sel_i,
  input  logic              jump_sel_i,
  input  logic              equal_i,
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [ADDR_W-1:0] br_tgt_i,
  input  logic [ADDR_W-1:0] jmp_tgt_i,
  output next_src_e         src_o,
  output logic [ADDR_W-1:0] pc_next_o
);
  // jump outranks branch
  always_comb begin
    if (jump_sel_i)                   src_o = SRC_JUMP;
    else if (branch_sel_i && equal_i) src_o = SRC_BRANCH;
    else                              src_o = SRC_SEQ;
  end

  always_comb begin
    unique case (src_o)
      SRC_JUMP:   pc_next_o = jmp_tgt_i;
      SRC_BRANCH: pc_next_o = br_tgt_i;
      default:    pc_next_o = seq_i;
    endcase
  end
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
  import fetch_pc_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          INSTR_W  = 32,
  parameter int          IMM_W    = 16,
  parameter int          TGT_W    = 26,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               branch_sel_i,
  input  logic               jump_sel_i,
  input  logic               equal_i,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [ADDR_W-1:0]  pc_plus4_o
);
  localparam int SX_W = ADDR_W - IMM_W - 2;

  logic [ADDR_W-1:0] pc_q, pc_next, br_tgt, jmp_tgt;
  next_src_e         src;

  fetch_pc_seq #(.ADDR_W(ADDR_W), .STEP(4)) u_seq (
    .pc_i       (pc_q),
    .pc_plus4_o (pc_plus4_o)
  );

  fetch_pc_targets #(
    .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .IMM_W(IMM_W), .TGT_W(TGT_W)
  ) u_tgt (
    .pc_plus4_i (pc_plus4_o),
    .instr_i    (instr_i),
    .br_tgt_o   (br_tgt),
    .jmp_tgt_o  (jmp_tgt)
  );

  fetch_pc_select #(.ADDR_W(ADDR_W)) u_sel (
    .branch_sel_i (branch_sel_i),
    .jump_sel_i   (jump_sel_i),
    .equal_i      (equal_i),
    .seq_i        (pc_plus4_o),
    .br_tgt_i     (br_tgt),
    .jmp_tgt_i    (jmp_tgt),
    .src_o        (src),
    .pc_next_o    (pc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= ADDR_W'(RESET_PC);
    else         pc_q <= pc_next;
  end

  assign pc_o = pc_q;

  // one-edge-after-reset qualifier for $past-based checks
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  logic [ADDR_W-1:0] chk_off;
  assign chk_off = {{SX_W{instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0], 2'b00};

  // R2 R4
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (!$past(jump_sel_i) && !($past(branch_sel_i) && $past(equal_i)))
      |-> pc_o == $past(pc_o) + ADDR_W'(4));

  // R5 R6
  branch_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (!$past(jump_sel_i) && $past(branch_sel_i) && $past(equal_i))
      |-> pc_o == $past(pc_plus4_o) + $past(chk_off));

  // R7
  jump_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    $past(jump_sel_i) |-> pc_o[TGT_W+1:2] == $past(instr_i[TGT_W-1:0]));

  // R8
  jump_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($past(jump_sel_i) && $past(branch_sel_i) && $past(equal_i))
      |-> src_is_jump_q);

  logic src_is_jump_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_is_jump_q <= 1'b0;
    else         src_is_jump_q <= (src == SRC_JUMP);
  end

  // R9
  pc_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);
endmodule

// File: tb/sim_fetch_pc_unit.sv
module sim_fetch_pc_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i = '0;
  logic        branch_sel_i = 1'b0;
  logic        jump_sel_i = 1'b0;
  logic        equal_i = 1'b0;
  logic [31:0] pc_o, pc_plus4_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] model_pc;

  always #10 clk_i = ~clk_i;

  fetch_pc_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i),
    .branch_sel_i(branch_sel_i), .jump_sel_i(jump_sel_i), .equal_i(equal_i),
    .pc_o(pc_o), .pc_plus4_o(pc_plus4_o)
  );

  function automatic logic [31:0] exp_next(logic [31:0] pc, logic [31:0] ins,
                                           logic br, logic jp, logic eq);
    logic [31:0] p4;
    p4 = pc + 32'd4;
    if (jp)             return {p4[31:28], ins[25:0], 2'b00};
    else if (br && eq)  return p4 + {{14{ins[15]}}, ins[15:0], 2'b00};
    else                return p4;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic br, logic jp, logic eq, logic [31:0] ins);
    if (jp && br && eq) return "R8";
    if (jp)             return "R7";
    if (br && eq)       return ins[15] ? "R6" : "R5";
    if (br || eq)       return "R4";
    return "R2";
  endfunction

  // inputs change on the falling edge; outputs checked on the next falling edge
  task automatic step(logic [31:0] ins, logic br, logic jp, logic eq);
    string t;
    instr_i = ins; branch_sel_i = br; jump_sel_i = jp; equal_i = eq;
    t = tag_of(br, jp, eq, ins);
    @(negedge clk_i);
    model_pc = exp_next(model_pc, ins, br, jp, eq);
    check(t, pc_o, model_pc);
    check("R3", pc_plus4_o, model_pc + 32'd4);
    check("R9", {30'd0, pc_o[1:0]}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_pc = 32'd0;
    repeat (3) @(negedge clk_i);
    check("R1", pc_o, 32'd0);
    rst_ni = 1'b1;
    check("R1", pc_o, 32'd0);
    // directed corners
    step(32'h0000_0000, 1'b0, 1'b0, 1'b0);          // R2 -> 4
    step(32'h0000_FFFE, 1'b1, 1'b0, 1'b1);          // R6 wrap: 8-8 = 0
    step(32'h0000_FFFE, 1'b1, 1'b0, 1'b1);          // R6 wrap: 4-8 = FFFFFFFC
    step(32'h0000_8000, 1'b1, 1'b0, 1'b1);          // R6 most negative offset
    step(32'h0312_3456, 1'b0, 1'b1, 1'b0);          // R7 region keeps upper bits
    step(32'h0000_7FFF, 1'b1, 1'b0, 1'b1);          // R5 most positive offset
    step(32'h0000_0010, 1'b1, 1'b0, 1'b0);          // R4 eq low
    step(32'h0000_0010, 1'b0, 1'b0, 1'b1);          // R4 select low
    step(32'h0000_0040, 1'b1, 1'b1, 1'b1);          // R8 jump wins
    step(32'h0000_FFFF, 1'b1, 1'b0, 1'b1);          // R6 backward by one word: stays
    // random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom();
      step($urandom(), r[0] & r[1], r[2] & r[3] & r[4], r[5]);
    end
    // asynchronous reset mid-run
    #3 rst_ni = 1'b0;
    #2 check("R1", pc_o, 32'd0);
    @(negedge clk_i);
    check("R1", pc_o, 32'd0);
    rst_ni = 1'b1;
    model_pc = 32'd0;
    step(32'h0000_0003, 1'b0, 1'b0, 1'b0);          // R1 first fetch then step
    step(32'h0000_0003, 1'b1, 1'b0, 1'b1);          // R5
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule